// File: doc/BRIEF.md
# Relay and Host Transmit Source Arbiter

This block decides, one whole frame at a time, which of two frame sources may drive a single MAC transmitter. One source is the host DMA, which asks to send frames built by software. The other is the relay path, which holds frames received on the opposite port in a relay buffer. The buffer is shared between the two relay directions. Each source raises a request, gets a grant, and keeps that grant until it signals the last cycle of its frame.

When both sources are waiting, a programmable policy breaks the tie. By default the winner alternates between the two; a mode bit can make the host win instead. On top of that policy sits an overflow guard. At every frame boundary the relay buffer fill level for this direction is compared with a programmable threshold. At or above the threshold the relay source wins outright. The threshold is limited to the share of the 6 KB relay buffer that software has given to this direction. One instance serves one transmitter, so each relay direction has its own threshold, mode and share.

Top module: `tx_source_arbiter`

## Requirements
- R1: After synchronous reset both grants are low. The mode reads 0 (alternating). The threshold reads 96. The share code reads 2.
- R2: If only one source requests when a decision is made, that source is granted whatever the mode, threshold or fill level.
- R3: With mode 0, both requesting and no urgency, the winner alternates. The first contest after reset goes to the host, and each later contest goes to the source not granted most recently.
- R4: With mode 1, both requesting and no urgency, the host always wins.
- R5: Urgency holds when the fill level (bytes) is >= the effective threshold. The effective threshold is the threshold field times 64. When both sources request and urgency holds, the relay source wins in either mode. A threshold of 0 makes every contest urgent.
- R6: The effective threshold never exceeds this direction's share of the buffer. The share is (code+1)*1024 bytes for codes 0 to 4, and codes 5 to 7 all mean 5120 bytes.
- R7: A grant holds until the granted source raises its frame end. The other source's frame end, a dropped request and fill changes during the frame have no effect.
- R8: A grant rises on the clock edge that samples the request in idle. After the granted frame end is sampled, both grants are low for one cycle, and the next grant can appear on the following edge.
- R9: Register map: address 0 bit 0 is the mode. Address 1 bits 6:0 are the threshold. Address 2 bits 2:0 are the share code. Writes to address 3 and to bits above each field have no effect. Read data shows the fields zero-extended.
- R10: The two grants are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | Host DMA has a frame to send |
| host_frame_end | input | 1 | Last cycle of the host frame |
| host_grant | output | 1 | Transmitter given to the host |
| relay_req | input | 1 | Relay buffer holds a frame for this port |
| relay_frame_end | input | 1 | Last cycle of the relay frame |
| relay_grant | output | 1 | Transmitter given to the relay path |
| relay_fill | input | FILL_W | Relay buffer fill level for this direction, in bytes |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for reg_addr |

## Verification
The hardest case to reach from the ports is the boundary where the clamp to the buffer share, and not the threshold field, decides urgency. It needs a small share code, a large threshold field and a fill level one byte either side of the share size, all present at a decision cycle with both sources waiting. The vector table sets all three registers before each contest. It places fill levels exactly at and just below each effective threshold, including a saturated share code. The alternating order carries over from one vector to the next, so the expected winners follow the running history. Directed steps then change the fill level and the other source's frame end in the middle of a granted frame.

// File: rtl/tsa_pkg.sv
package tsa_pkg;
    localparam int DATA_W         = 16;
    localparam int ADDR_W         = 2;
    localparam int THR_W          = 7;
    localparam int ALLOC_W        = 3;
    localparam int UNIT_SHIFT     = 6;
    localparam int ALLOC_STEP     = 1024;
    localparam int ALLOC_MAX_CODE = 4;
    localparam int RESET_THR      = 96;
    localparam int RESET_ALLOC    = 2;

    localparam logic [ADDR_W-1:0] ADR_MODE  = 2'd0;
    localparam logic [ADDR_W-1:0] ADR_THR   = 2'd1;
    localparam logic [ADDR_W-1:0] ADR_ALLOC = 2'd2;

    typedef enum logic [1:0] {
        ARB_IDLE  = 2'd0,
        ARB_HOST  = 2'd1,
        ARB_RELAY = 2'd2
    } arb_state_t;

    typedef struct packed {
        logic               host_first;
        logic [THR_W-1:0]   thr;
        logic [ALLOC_W-1:0] alloc;
    } arb_cfg_t;

    function automatic logic [ALLOC_W-1:0] sat_alloc(input logic [ALLOC_W-1:0] code);
        return (int'(code) > ALLOC_MAX_CODE) ? ALLOC_W'(ALLOC_MAX_CODE) : code;
    endfunction
endpackage

// File: rtl/tsa_cfg_regs.sv
module tsa_cfg_regs
    import tsa_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output arb_cfg_t          cfg
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg.host_first <= 1'b0;
            cfg.thr        <= THR_W'(RESET_THR);
            cfg.alloc      <= ALLOC_W'(RESET_ALLOC);
        end else if (we) begin
            case (addr)
                ADR_MODE:  cfg.host_first <= wdata[0];
                ADR_THR:   cfg.thr        <= wdata[THR_W-1:0];
                ADR_ALLOC: cfg.alloc      <= wdata[ALLOC_W-1:0];
                default:   ;
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            ADR_MODE:  rdata[0]         = cfg.host_first;
            ADR_THR:   rdata[THR_W-1:0] = cfg.thr;
            ADR_ALLOC: rdata[ALLOC_W-1:0] = cfg.alloc;
            default:   rdata = '0;
        endcase
    end

    AST_SPARE_ADDR_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (we && addr == 2'd3) |=> $stable(cfg)) else $error("spare address write changed config"); // R9
endmodule

// File: rtl/tsa_level_cmp.sv
module tsa_level_cmp
    import tsa_pkg::*;
#(
    parameter int FILL_W = 13
) (
    input  logic [FILL_W-1:0]  fill,
    input  logic [THR_W-1:0]   thr,
    input  logic [ALLOC_W-1:0] alloc,
    output logic               urgent
);
    localparam int THR_BYTES_W = THR_W + UNIT_SHIFT;
    localparam int CMP_W = ((FILL_W > THR_BYTES_W) ? FILL_W : THR_BYTES_W) + 1;

    logic [CMP_W-1:0]   thr_bytes;
    logic [CMP_W-1:0]   share_bytes;
    logic [CMP_W-1:0]   eff_bytes;
    logic [ALLOC_W-1:0] code_sat;

    assign code_sat    = sat_alloc(alloc);
    assign thr_bytes   = CMP_W'(thr) << UNIT_SHIFT;
    assign share_bytes = CMP_W'((int'(code_sat) + 1) * ALLOC_STEP);
    assign eff_bytes   = (thr_bytes < share_bytes) ? thr_bytes : share_bytes;
    assign urgent      = CMP_W'(fill) >= eff_bytes;
endmodule

// File: rtl/tsa_grant_fsm.sv
module tsa_grant_fsm
    import tsa_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic host_req,
    input  logic host_end,
    input  logic relay_req,
    input  logic relay_end,
    input  logic host_first,
    input  logic urgent,
    output logic host_grant,
    output logic relay_grant
);
    arb_state_t state;
    logic       last_host;
    logic       both;
    logic       pick_relay;

    assign both       = host_req && relay_req;
    assign pick_relay = both ? (urgent || (!host_first && last_host)) : relay_req;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ARB_IDLE;
            last_host <= 1'b0;
        end else begin
            case (state)
                ARB_IDLE: if (host_req || relay_req) begin
                    state     <= pick_relay ? ARB_RELAY : ARB_HOST;
                    last_host <= !pick_relay;
                end
                ARB_HOST:  if (host_end)  state <= ARB_IDLE;
                ARB_RELAY: if (relay_end) state <= ARB_IDLE;
                default:   state <= ARB_IDLE;
            endcase
        end
    end

    assign host_grant  = (state == ARB_HOST);
    assign relay_grant = (state == ARB_RELAY);

    AST_ONE_GRANT: assert property (@(posedge clk) disable iff (rst)
        !(host_grant && relay_grant)) else $error("both grants high"); // R10
    AST_HOST_HOLD: assert property (@(posedge clk) disable iff (rst)
        (host_grant && !host_end) |=> host_grant) else $error("host grant dropped early"); // R7
    AST_RELAY_HOLD: assert property (@(posedge clk) disable iff (rst)
        (relay_grant && !relay_end) |=> relay_grant) else $error("relay grant dropped early"); // R7
    AST_GAP_AFTER_END: assert property (@(posedge clk) disable iff (rst)
        ((host_grant && host_end) || (relay_grant && relay_end)) |=> !(host_grant || relay_grant))
        else $error("no idle cycle after frame end"); // R8
    AST_GRANT_HAD_REQ: assert property (@(posedge clk) disable iff (rst)
        $rose(relay_grant) |-> $past(relay_req)) else $error("relay granted without request"); // R2
    AST_URGENT_WINS: assert property (@(posedge clk) disable iff (rst)
        (!host_grant && !relay_grant && both && urgent) |=> relay_grant)
        else $error("urgent contest not won by relay"); // R5
endmodule

// File: rtl/tx_source_arbiter.sv
module tx_source_arbiter
    import tsa_pkg::*;
#(
    parameter int FILL_W = 13
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_req,
    input  logic              host_frame_end,
    output logic              host_grant,
    input  logic              relay_req,
    input  logic              relay_frame_end,
    output logic              relay_grant,
    input  logic [FILL_W-1:0] relay_fill,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata
);
    arb_cfg_t cfg;
    logic     urgent;

    tsa_cfg_regs i_regs (
        .clk   (clk),
        .rst   (rst),
        .we    (reg_we),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .rdata (reg_rdata),
        .cfg   (cfg)
    );

    tsa_level_cmp #(.FILL_W(FILL_W)) i_cmp (
        .fill   (relay_fill),
        .thr    (cfg.thr),
        .alloc  (cfg.alloc),
        .urgent (urgent)
    );

    tsa_grant_fsm i_fsm (
        .clk         (clk),
        .rst         (rst),
        .host_req    (host_req),
        .host_end    (host_frame_end),
        .relay_req   (relay_req),
        .relay_end   (relay_frame_end),
        .host_first  (cfg.host_first),
        .urgent      (urgent),
        .host_grant  (host_grant),
        .relay_grant (relay_grant)
    );

    AST_RESET_NO_GRANT: assert property (@(posedge clk)
        rst |=> !(host_grant || relay_grant)) else $error("grant out of reset"); // R1
endmodule

// File: tb/test_tx_source_arbiter.sv
`timescale 1ns/100ps
module test_tx_source_arbiter;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_req = 1'b0, host_frame_end = 1'b0, host_grant;
    logic        relay_req = 1'b0, relay_frame_end = 1'b0, relay_grant;
    logic [12:0] relay_fill = '0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    tx_source_arbiter i_tx_source_arbiter (
        .clk(clk), .rst(rst),
        .host_req(host_req), .host_frame_end(host_frame_end), .host_grant(host_grant),
        .relay_req(relay_req), .relay_frame_end(relay_frame_end), .relay_grant(relay_grant),
        .relay_fill(relay_fill),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    // {mode, thr[6:0], share[2:0], fill[12:0], host_req, relay_req, expect[1:0]}
    // expect: 0 none, 1 host, 2 relay
    localparam int NV = 18;
    localparam logic [27:0] VEC [NV] = '{
        {1'b0, 7'd96,  3'd2, 13'd0,    1'b1, 1'b1, 2'd1}, // R3 first contest to host
        {1'b0, 7'd96,  3'd2, 13'd0,    1'b1, 1'b1, 2'd2}, // R3
        {1'b0, 7'd96,  3'd2, 13'd0,    1'b1, 1'b1, 2'd1}, // R3
        {1'b0, 7'd96,  3'd2, 13'd0,    1'b0, 1'b1, 2'd2}, // R2 lone relay
        {1'b0, 7'd96,  3'd2, 13'd0,    1'b1, 1'b1, 2'd1}, // R3 after relay
        {1'b1, 7'd96,  3'd2, 13'd0,    1'b1, 1'b1, 2'd1}, // R4
        {1'b1, 7'd96,  3'd2, 13'd0,    1'b1, 1'b1, 2'd1}, // R4 twice
        {1'b1, 7'd10,  3'd2, 13'd640,  1'b1, 1'b1, 2'd2}, // R5 exactly at threshold
        {1'b1, 7'd10,  3'd2, 13'd639,  1'b1, 1'b1, 2'd1}, // R5 one byte below
        {1'b0, 7'd10,  3'd2, 13'd700,  1'b1, 1'b1, 2'd2}, // R5 mode 0
        {1'b0, 7'd10,  3'd2, 13'd0,    1'b1, 1'b1, 2'd1}, // R3
        {1'b1, 7'd127, 3'd0, 13'd1024, 1'b1, 1'b1, 2'd2}, // R6 clamp to 1024
        {1'b1, 7'd127, 3'd0, 13'd1023, 1'b1, 1'b1, 2'd1}, // R6
        {1'b1, 7'd0,   3'd2, 13'd5000, 1'b1, 1'b0, 2'd1}, // R2 lone host while urgent
        {1'b0, 7'd0,   3'd2, 13'd0,    1'b1, 1'b1, 2'd2}, // R5 threshold 0
        {1'b1, 7'd127, 3'd7, 13'd5120, 1'b1, 1'b1, 2'd2}, // R6 saturated share
        {1'b1, 7'd127, 3'd7, 13'd5119, 1'b1, 1'b1, 2'd1}, // R6
        {1'b1, 7'd127, 3'd7, 13'd0,    1'b0, 1'b0, 2'd0}  // R2 nobody requests
    };

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int grant_code();
        return (host_grant && relay_grant) ? 3 : relay_grant ? 2 : host_grant ? 1 : 0;
    endfunction

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_check(input string tag, input logic [1:0] a, input int exp);
        reg_addr = a;
        #0.5;
        check(tag, int'(reg_rdata), exp);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 grants in reset", grant_code(), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 grants after reset", grant_code(), 0);
        rd_check("R1 mode default", 2'd0, 0);
        rd_check("R1 threshold default", 2'd1, 96);
        rd_check("R1 share default", 2'd2, 2);

        for (int i = 0; i < NV; i++) begin
            wr(2'd0, {15'd0, VEC[i][27]});
            wr(2'd1, {9'd0, VEC[i][26:20]});
            wr(2'd2, {13'd0, VEC[i][19:17]});
            relay_fill = VEC[i][16:4];
            host_req   = VEC[i][3];
            relay_req  = VEC[i][2];
            @(negedge clk);
            check($sformatf("R2-R6 vector %0d (R10 onehot)", i), grant_code(), int'(VEC[i][1:0]));
            host_frame_end  = host_grant;
            relay_frame_end = relay_grant;
            host_req  = 1'b0;
            relay_req = 1'b0;
            @(negedge clk);
            host_frame_end  = 1'b0;
            relay_frame_end = 1'b0;
        end

        // R7: hold through foreign frame end, dropped request and fill change
        wr(2'd1, 16'd10);
        relay_fill = 13'd0;
        host_req = 1'b1;
        @(negedge clk);
        check("R7 host granted", grant_code(), 1);
        host_req = 1'b0;
        relay_req = 1'b1;
        relay_frame_end = 1'b1;
        relay_fill = 13'd8000;
        @(negedge clk);
        check("R7 host held", grant_code(), 1);
        relay_frame_end = 1'b0;
        @(negedge clk);
        check("R7 host still held", grant_code(), 1);
        host_frame_end = 1'b1;
        @(negedge clk);
        host_frame_end = 1'b0;
        check("R8 idle cycle after end", grant_code(), 0);
        @(negedge clk);
        check("R8 next grant one cycle later", grant_code(), 2);
        relay_req = 1'b0;
        relay_frame_end = 1'b1;
        @(negedge clk);
        relay_frame_end = 1'b0;
        check("R8 relay released", grant_code(), 0);

        // R9: spare address and upper bits ignored
        wr(2'd3, 16'hFFFF);
        rd_check("R9 mode after spare write", 2'd0, 1);
        rd_check("R9 threshold after spare write", 2'd1, 10);
        rd_check("R9 share after spare write", 2'd2, 7);
        wr(2'd1, 16'hFF85);
        rd_check("R9 threshold upper bits dropped", 2'd1, 5);
        rd_check("R9 spare reads zero", 2'd3, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule